// File: doc/BRIEF.md
# Single-Precision Floating-Point Subtractor

This unit computes `minuend - subtrahend` on two 32-bit IEEE 754 binary32 words under one of four selectable rounding modes. It returns the correctly rounded 32-bit difference and a flag that reports an invalid operation. The datapath is combinational and ends in one output register, so the answer for inputs presented before a rising clock edge appears on the outputs just after that edge. The latency is therefore one clock.

Each operand is first sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. A fixed priority chain settles every pair that involves a NaN, an infinity or a zero. The remaining finite, nonzero pairs go through the arithmetic path. That path negates the subtrahend's sign and lines up the significands using three extra low bits. The bit shifted past the end is kept as a sticky OR. The path then adds or subtracts, renormalizes and rounds. Subnormal inputs and outputs are fully supported, so underflow is gradual.

Rounding-mode encoding on `rnd_mode`: 0 = to nearest, ties to even; 1 = toward zero; 2 = toward +infinity; 3 = toward -infinity.

Top module: `fpsub_unit`

## Requirements
- R1: While `rst_n` is low, `diff` and `invalid` are 0. After reset, both outputs present the result for the inputs sampled at the previous rising edge.
- R2: A signalling NaN (exponent 255, fraction nonzero, fraction bit 22 clear) takes priority. If the minuend is one, the result is the minuend with bit 22 set. Otherwise, if the subtrahend is one, the result is the subtrahend with bit 22 set. `invalid` is 1 in both cases. No NaN ever leaves the unit with bit 22 clear.
- R3: Without a signalling NaN, a quiet-NaN minuend is returned unchanged. Otherwise a quiet-NaN subtrahend is returned unchanged. `invalid` stays 0.
- R4: Infinity minus an infinity of the same sign gives 0x7FC00000 with `invalid` = 1. Infinity minus an infinity of the opposite sign returns the minuend.
- R5: A finite minuend minus an infinite subtrahend gives infinity with the opposite of the subtrahend's sign. An infinite minuend minus a finite subtrahend returns the minuend.
- R6: Zero minus zero with different signs returns the minuend. With equal signs it gives +0, or -0 when `rnd_mode` is 3.
- R7: A nonzero finite minuend minus a zero returns the minuend unchanged. Zero minus a nonzero finite subtrahend returns the subtrahend with bit 31 inverted.
- R8: For finite nonzero operands in mode 0, the result is the exact difference rounded to nearest, with ties going to the even significand.
- R9: In modes 1, 2 and 3, the exact difference is rounded toward zero, toward +infinity and toward -infinity respectively. Mode 1 never produces an infinity from finite operands.
- R10: An exact difference of zero from finite operands (other than the R6 different-sign case) gives +0, or -0 in mode 3.
- R11: A rounded magnitude beyond the largest finite value gives infinity in mode 0. In the directed modes it gives infinity only when the rounding direction points away from zero. Otherwise it gives the largest finite magnitude, 0x7F7FFFFF with the result's sign.
- R12: Subnormal operands enter with their true value. Results below the smallest normal are returned as subnormals with exponent field 0, or as zero.
- R13: `invalid` is 1 exactly in the R2 and R4 invalid cases. Whenever it is 1, `diff` is a quiet NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| minuend | input | 32 | Left operand, binary32 |
| subtrahend | input | 32 | Right operand, binary32 |
| rnd_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| diff | output | 32 | Registered difference, binary32 |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The hardest cases to reach from the ports involve bits the aligner throws away. One is a rounding tie or a sticky-only remainder that decides the last bit after a large exponent gap. The other is the carry into the exponent that turns the largest finite value into an overflow. The sweep covers these by building operands from a grid of exponent fields chosen to sit around the shifter cap (0, 1, 2, 23 to 25, 126 to 128, 253 to 255). Each exponent is paired with edge fractions (0, 1, only bit 22, all ones) and both signs, and every pair is run under all four modes. A second pass uses pseudo-random operands whose exponents differ by only a few steps. This drives deep cancellations and guard/round/sticky patterns. Expected results come from an exact wide-integer difference that is rounded in the bench.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int GRS_W  = 3;
    localparam int ALN_W  = SIG_W + GRS_W;
    localparam int LZ_W   = $clog2(ALN_W + 1);
    localparam int EW     = EXP_W + 2;

    localparam logic [EXP_W-1:0] EXP_TOP = '1;
    localparam logic [EXP_W-1:0] EXP_BIG = EXP_TOP - 1'b1;

    typedef enum logic [2:0] {
        CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
    } fclass_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0, RM_ZERO = 2'd1, RM_UP = 2'd2, RM_DOWN = 2'd3
    } rmode_e;
endpackage

// File: rtl/fpsub_classify.sv
module fpsub_classify
    import fpsub_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fclass_e           cls,
    output logic [EXP_W-1:0]  exp_eff,
    output logic [SIG_W-1:0]  sig
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    always_comb begin
        ex = word[WORD_W-2 -: EXP_W];
        fr = word[FRAC_W-1:0];
        if (ex == EXP_TOP) begin
            if (fr == '0)            cls = CL_INF;
            else if (fr[FRAC_W-1])   cls = CL_QNAN;
            else                     cls = CL_SNAN;
        end else if (ex == '0) begin
            cls = (fr == '0) ? CL_ZERO : CL_SUB;
        end else begin
            cls = CL_NORM;
        end
        // subnormals take the smallest normal exponent and no hidden bit
        exp_eff = (ex == '0) ? EXP_W'(1) : ex;
        sig     = {(ex != '0), fr};
    end
endmodule

// File: rtl/fpsub_special.sv
module fpsub_special
    import fpsub_pkg::*;
(
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] y,
    input  fclass_e           cx,
    input  fclass_e           cy,
    input  rmode_e            rm,
    output logic              take,
    output logic              inv,
    output logic [WORD_W-1:0] res
);
    localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);
    localparam logic [WORD_W-1:0] INDEF     = {1'b0, EXP_TOP, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-2:0] INF_MAG   = {EXP_TOP, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-1:0] SIGN_BIT  = {1'b1, {(WORD_W-1){1'b0}}};

    // fixed priority chain: signalling NaN, quiet NaN, infinities, zeros
    always_comb begin
        take = 1'b1;
        inv  = 1'b0;
        res  = x;
        if (cx == CL_SNAN) begin
            res = x | QUIET_BIT;
            inv = 1'b1;
        end else if (cy == CL_SNAN) begin
            res = y | QUIET_BIT;
            inv = 1'b1;
        end else if (cx == CL_QNAN) begin
            res = x;
        end else if (cy == CL_QNAN) begin
            res = y;
        end else if (cx == CL_INF && cy == CL_INF) begin
            if (x[WORD_W-1] == y[WORD_W-1]) begin
                res = INDEF;
                inv = 1'b1;
            end else begin
                res = x;
            end
        end else if (cy == CL_INF) begin
            res = {~y[WORD_W-1], INF_MAG};
        end else if (cx == CL_INF) begin
            res = x;
        end else if (cx == CL_ZERO && cy == CL_ZERO) begin
            res = (x[WORD_W-1] != y[WORD_W-1]) ? x
                                               : {(rm == RM_DOWN), {(WORD_W-1){1'b0}}};
        end else if (cy == CL_ZERO) begin
            res = x;
        end else if (cx == CL_ZERO) begin
            res = y ^ SIGN_BIT;
        end else begin
            take = 1'b0;
        end
    end
endmodule

// File: rtl/fpsub_core.sv
module fpsub_core
    import fpsub_pkg::*;
(
    input  logic              sgn_x,
    input  logic [EXP_W-1:0]  exp_x,
    input  logic [SIG_W-1:0]  sig_x,
    input  logic              sgn_y,
    input  logic [EXP_W-1:0]  exp_y,
    input  logic [SIG_W-1:0]  sig_y,
    input  rmode_e            rm,
    output logic [WORD_W-1:0] res
);
    localparam logic [EXP_W-1:0] ALN_LIM = EXP_W'(ALN_W);

    logic              sgn_yn, swap, eff_add, sgn_r, sticky, found, rnd_up, inexact;
    logic [EXP_W-1:0]  e_big, e_small, e_dist;
    logic [ALN_W-1:0]  m_big, m_small, m_aln, m_norm, m_fin;
    logic [ALN_W:0]    m_sum;
    logic [EW-1:0]     e_wide, e_fin, e_rnd, lead_w, sh_w;
    logic [LZ_W-1:0]   lead;
    logic [SIG_W:0]    q;

    always_comb begin
        // subtraction becomes addition of the sign-inverted subtrahend
        sgn_yn  = ~sgn_y;
        swap    = {exp_y, sig_y} > {exp_x, sig_x};
        e_big   = swap ? exp_y : exp_x;
        e_small = swap ? exp_x : exp_y;
        m_big   = {(swap ? sig_y : sig_x), {GRS_W{1'b0}}};
        m_small = {(swap ? sig_x : sig_y), {GRS_W{1'b0}}};
        sgn_r   = swap ? sgn_yn : sgn_x;
        eff_add = (sgn_x == sgn_yn);

        // alignment with sticky collection; large gaps collapse to sticky only
        e_dist = e_big - e_small;
        sticky = 1'b0;
        if (e_dist >= ALN_LIM) begin
            m_aln = {{(ALN_W-1){1'b0}}, |m_small};
        end else begin
            sticky = |(m_small & ((ALN_W'(1) << e_dist) - ALN_W'(1)));
            m_aln  = (m_small >> e_dist) | {{(ALN_W-1){1'b0}}, sticky};
        end

        m_sum  = eff_add ? ({1'b0, m_big} + {1'b0, m_aln})
                         : ({1'b0, m_big} - {1'b0, m_aln});
        e_wide = {2'b00, e_big};
        if (m_sum[ALN_W]) begin
            m_norm = m_sum[ALN_W:1] | {{(ALN_W-1){1'b0}}, m_sum[0]};
            e_wide = e_wide + EW'(1);
        end else begin
            m_norm = m_sum[ALN_W-1:0];
        end

        // leading-zero count, shift capped so exponent never drops below 1
        found = 1'b0;
        lead  = '0;
        for (int i = ALN_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (m_norm[i]) found = 1'b1;
                else           lead  = lead + LZ_W'(1);
            end
        end
        lead_w = EW'(lead);
        sh_w   = (lead_w < e_wide) ? lead_w : (e_wide - EW'(1));
        m_fin  = m_norm << sh_w;
        e_fin  = e_wide - sh_w;

        inexact = |m_fin[GRS_W-1:0];
        unique case (rm)
            RM_NEAR: rnd_up = m_fin[GRS_W-1] & (|m_fin[GRS_W-2:0] | m_fin[GRS_W]);
            RM_ZERO: rnd_up = 1'b0;
            RM_UP:   rnd_up = ~sgn_r & inexact;
            RM_DOWN: rnd_up = sgn_r & inexact;
        endcase
        q     = {1'b0, m_fin[ALN_W-1:GRS_W]} + (SIG_W+1)'(rnd_up);
        e_rnd = e_fin;
        if (q[SIG_W]) begin
            q     = q >> 1;
            e_rnd = e_fin + EW'(1);
        end

        if (m_sum == '0) begin
            res = {(rm == RM_DOWN), {(WORD_W-1){1'b0}}};
        end else if (e_rnd >= EW'(EXP_TOP)) begin
            if (rm == RM_NEAR || (rm == RM_UP && !sgn_r) || (rm == RM_DOWN && sgn_r))
                res = {sgn_r, EXP_TOP, {FRAC_W{1'b0}}};
            else
                res = {sgn_r, EXP_BIG, {FRAC_W{1'b1}}};
        end else begin
            res = {sgn_r, (q[SIG_W-1] ? e_rnd[EXP_W-1:0] : {EXP_W{1'b0}}), q[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fpsub_unit.sv
module fpsub_unit
    import fpsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] minuend,
    input  logic [WORD_W-1:0] subtrahend,
    input  logic [1:0]        rnd_mode,
    output logic [WORD_W-1:0] diff,
    output logic              invalid
);
    logic [WORD_W-1:0] ops     [2];
    fclass_e           cls     [2];
    logic [EXP_W-1:0]  exp_eff [2];
    logic [SIG_W-1:0]  sig     [2];
    rmode_e            rm;
    logic              spec_take, spec_inv;
    logic [WORD_W-1:0] spec_res, core_res, next_res;
    logic              live_q;

    assign ops[0] = minuend;
    assign ops[1] = subtrahend;
    assign rm     = rmode_e'(rnd_mode);

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpsub_classify u_cls (
            .word    (ops[g]),
            .cls     (cls[g]),
            .exp_eff (exp_eff[g]),
            .sig     (sig[g])
        );
    end

    fpsub_special u_spec (
        .x (minuend), .y (subtrahend), .cx (cls[0]), .cy (cls[1]), .rm (rm),
        .take (spec_take), .inv (spec_inv), .res (spec_res)
    );

    fpsub_core u_core (
        .sgn_x (minuend[WORD_W-1]),    .exp_x (exp_eff[0]), .sig_x (sig[0]),
        .sgn_y (subtrahend[WORD_W-1]), .exp_y (exp_eff[1]), .sig_y (sig[1]),
        .rm (rm), .res (core_res)
    );

    assign next_res = spec_take ? spec_res : core_res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff    <= '0;
            invalid <= 1'b0;
            live_q  <= 1'b0;
        end else begin
            diff    <= next_res;
            invalid <= spec_take & spec_inv;
            live_q  <= 1'b1;
        end
    end

    assert_nan_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (diff[WORD_W-2 -: EXP_W] == EXP_TOP && diff[FRAC_W-1:0] != '0) |-> diff[FRAC_W-1]);

    assert_invalid_nan_R13: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (diff[WORD_W-2 -: EXP_W] == EXP_TOP && diff[FRAC_W-1]));

    assert_inf_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(minuend[WORD_W-2 -: EXP_W] != EXP_TOP
                         && subtrahend[WORD_W-2:0] == {EXP_TOP, {FRAC_W{1'b0}}}))
        |-> diff == {~$past(subtrahend[WORD_W-1]), EXP_TOP, {FRAC_W{1'b0}}});

    assert_cancel_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(minuend == subtrahend && minuend[WORD_W-2 -: EXP_W] != EXP_TOP))
        |-> diff == {($past(rnd_mode) == 2'd3), {(WORD_W-1){1'b0}}});

    assert_rz_finite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(rnd_mode == 2'd1 && minuend[WORD_W-2 -: EXP_W] != EXP_TOP
                         && subtrahend[WORD_W-2 -: EXP_W] != EXP_TOP))
        |-> diff[WORD_W-2 -: EXP_W] != EXP_TOP);

    assert_minus_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(subtrahend[WORD_W-2:0] == '0 && minuend[WORD_W-2:0] != '0
                         && minuend[WORD_W-2 -: EXP_W] != EXP_TOP))
        |-> diff == $past(minuend));
endmodule

// File: tb/fpsub_unit_test.sv
`timescale 1ns/1ps
module fpsub_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] minuend = '0, subtrahend = '0;
    logic [1:0]  rnd_mode = '0;
    logic [31:0] diff;
    logic        invalid;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fpsub_unit uut (.clk(clk), .rst_n(rst_n), .minuend(minuend), .subtrahend(subtrahend),
                    .rnd_mode(rnd_mode), .diff(diff), .invalid(invalid));

    function automatic logic [299:0] mag_of(input logic [31:0] w);
        logic [299:0] m;
        m = '0;
        if (w[30:23] == 8'd0) m[22:0] = w[22:0];
        else begin
            m[23:0] = {1'b1, w[22:0]};
            m = m << (w[30:23] - 8'd1);
        end
        return m;
    endfunction

    function automatic logic [31:0] pack(input logic s, input logic [299:0] mag, input logic [1:0] rm);
        int p, sh, ef;
        logic [299:0] one, rem, half, qq;
        logic [24:0] q;
        logic inc;
        p = 0;
        for (int i = 0; i < 300; i++) if (mag[i]) p = i;
        if (p <= 23) return {s, mag[30:0]};
        sh = p - 23;
        one = 300'd1;
        qq = mag >> sh;
        q = qq[24:0];
        rem = mag & ((one << sh) - one);
        half = one << (sh - 1);
        case (rm)
            2'd0: inc = (rem > half) || (rem == half && q[0]);
            2'd1: inc = 1'b0;
            2'd2: inc = !s && rem != '0;
            default: inc = s && rem != '0;
        endcase
        q = q + {24'd0, inc};
        ef = sh + 1;
        if (q[24]) begin q = q >> 1; ef = ef + 1; end
        if (ef >= 255) begin
            if (rm == 2'd0 || (rm == 2'd2 && !s) || (rm == 2'd3 && s)) return {s, 8'hFF, 23'd0};
            return {s, 8'hFE, 23'h7FFFFF};
        end
        return {s, ef[7:0], q[22:0]};
    endfunction

    // returns {invalid, result}
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm);
        logic an, bn, as_, bs_, ai, bi, az, bz, s;
        logic [299:0] ma, mb, mag;
        an = a[30:23] == 8'hFF && a[22:0] != 0; as_ = an && !a[22];
        bn = b[30:23] == 8'hFF && b[22:0] != 0; bs_ = bn && !b[22];
        ai = a[30:0] == 31'h7F800000; bi = b[30:0] == 31'h7F800000;
        az = a[30:0] == 0; bz = b[30:0] == 0;
        if (as_) return {1'b1, a | 32'h0040_0000};
        if (bs_) return {1'b1, b | 32'h0040_0000};
        if (an) return {1'b0, a};
        if (bn) return {1'b0, b};
        if (ai && bi) return (a[31] == b[31]) ? {1'b1, 32'h7FC00000} : {1'b0, a};
        if (bi) return {1'b0, ~b[31], 31'h7F800000};
        if (ai) return {1'b0, a};
        ma = mag_of(a); mb = mag_of(b);
        if (a[31] != b[31]) begin mag = ma + mb; s = a[31]; end
        else if (ma >= mb) begin mag = ma - mb; s = a[31]; end
        else begin mag = mb - ma; s = ~a[31]; end
        if (mag == '0) begin
            if (az && bz && a[31] != b[31]) return {1'b0, a};
            return {1'b0, (rm == 2'd3), 31'd0};
        end
        return {1'b0, pack(s, mag, rm)};
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [31:0] b,
                                     input logic [1:0] rm, input logic [31:0] r);
        logic an, bn, ai, bi;
        an = a[30:23] == 8'hFF && a[22:0] != 0;
        bn = b[30:23] == 8'hFF && b[22:0] != 0;
        ai = a[30:23] == 8'hFF && !an;
        bi = b[30:23] == 8'hFF && !bn;
        if ((an && !a[22]) || (bn && !b[22])) return "R2";
        if (an || bn) return "R3";
        if (ai && bi) return "R4";
        if (ai || bi) return "R5";
        if (a[30:0] == 0 && b[30:0] == 0) return "R6";
        if (a[30:0] == 0 || b[30:0] == 0) return "R7";
        if (r[30:0] == 0) return "R10";
        if (r[30:23] == 8'hFF || r[30:0] == 31'h7F7FFFFF) return "R11";
        if (a[30:23] == 0 || b[30:23] == 0 || r[30:23] == 0) return "R12";
        if (rm == 2'd0) return "R8";
        return "R9";
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm);
        logic [32:0] ev;
        string t;
        @(negedge clk);
        minuend = a; subtrahend = b; rnd_mode = rm;
        @(negedge clk);
        ev = model(a, b, rm);
        t = tag_of(a, b, rm, ev[31:0]);
        tests++;
        if (diff !== ev[31:0]) begin
            fails++;
            $display("FAIL %s a=%h b=%h rm=%0d diff actual=%h expected=%h", t, a, b, rm, diff, ev[31:0]);
        end
        tests++;
        if (invalid !== ev[32]) begin
            fails++;
            $display("FAIL R13 a=%h b=%h rm=%0d invalid actual=%0b expected=%0b", a, b, rm, invalid, ev[32]);
        end
    endtask

    function automatic logic [31:0] grid(input int v);
        logic [7:0] e;
        logic [22:0] f;
        case (v >> 3)
            0: e = 8'd0;   1: e = 8'd1;   2: e = 8'd2;   3: e = 8'd23;
            4: e = 8'd24;  5: e = 8'd25;  6: e = 8'd126; 7: e = 8'd127;
            8: e = 8'd128; 9: e = 8'd253; 10: e = 8'd254; default: e = 8'd255;
        endcase
        case ((v >> 1) & 3)
            0: f = 23'd0; 1: f = 23'd1; 2: f = 23'h400000; default: f = 23'h7FFFFF;
        endcase
        return {v[0], e, f};
    endfunction

    initial begin
        logic [31:0] lf;
        minuend = 32'h3F80_0000; subtrahend = 32'hFFA0_0000; rnd_mode = 2'd2;
        repeat (3) @(negedge clk);
        tests++;
        if (diff !== 32'd0 || invalid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset diff actual=%h expected=00000000 invalid actual=%0b expected=0", diff, invalid);
        end
        rst_n = 1'b1;
        // R1 latency: outputs follow the inputs one edge later (checked by every run below)
        for (int i = 0; i < 96; i++)
            for (int j = 0; j < 96; j++)
                for (int m = 0; m < 4; m++)
                    run(grid(i), grid(j), m[1:0]);
        lf = 32'h1234_5678;
        for (int k = 0; k < 6000; k++) begin
            logic [31:0] a, b;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            a = lf;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            b = {lf[31], a[30:23] + {5'd0, lf[2:0]} - 8'd3, lf[26:4]};
            if (a[30:23] == 8'hFF) a[30:23] = 8'hFE;
            run(a, b, lf[28:27]);
        end
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule